// File: doc/BRIEF.md
# Synchronous Presettable Binary Counter with Terminal-Count Carry

This block is a small binary up-counter whose every state change happens on the rising clock edge. Its controls are ranked in a fixed order. A synchronous clear forces the count to zero. A parallel load copies an input word into the register. Two enables must both be high for the register to advance, and the register holds its value in every other case. Nothing acts asynchronously.

A terminal-count output goes high while the register holds its all-ones value and the chain-side enable is high. That output feeds the chain-side enable of the next stage, so identical stages can be joined into a wider synchronous counter. The count-side enable is shared by all stages and pauses the whole chain at once.

The register has no power-up value. A clear must be applied before the count means anything.

Top module: `sync_preset_counter`

## Requirements
- R1: While sclr_n is low at a rising edge, q becomes 0 after that edge, whatever ld_n, cnt_en, chain_en and d_in are.
- R2: While sclr_n is high and ld_n is low at a rising edge, q becomes d_in after that edge, and cnt_en and chain_en have no effect.
- R3: While sclr_n, ld_n, cnt_en and chain_en are all high at a rising edge, q becomes q+1 after that edge.
- R4: While sclr_n and ld_n are high and either cnt_en or chain_en is low at a rising edge, q keeps its value.
- R5: Counting from the all-ones value (15 at WIDTH=4) gives 0 on the next counting edge.
- R6: tc_out is high exactly when chain_en is high and every bit of q is 1. It follows those inputs combinationally and does not depend on cnt_en, ld_n or sclr_n.
- R7: q changes only at rising clock edges. Control or data changes between edges leave q unchanged until the next edge.
- R8: Two stages joined as described (upper chain_en driven by the lower tc_out, shared clock and cnt_en) count through 0..255 and wrap to 0 as one 8-bit counter. The upper stage's tc_out goes high at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| sclr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count-side enable, active high |
| chain_en | input | 1 | Chain-side enable, active high; also gates tc_out |
| d_in | input | WIDTH | Parallel load word |
| q | output | WIDTH | Current count |
| tc_out | output | 1 | Terminal-count carry for the next stage |

## Verification
A wrong register state is visible on q one edge after it is created. It also shows on tc_out at once whenever the bad state is or is mistaken for all ones with chain_en high. A priority error, such as load winning over clear or an enable that is ignored, gives a wrong q on the first edge where the conflicting controls are applied together. The bench therefore sweeps every starting value against every control combination and compares each edge. A fault in the increment carry chain can stay hidden until a particular low-bit pattern is reached. The full 256-step cascade run brings out such faults, and cross-stage carry faults, within one pass.

// File: rtl/spc_pkg.sv
`timescale 1ns/1ps
package spc_pkg;

    // Operating modes, listed lowest to highest priority.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } spc_mode_e;

    // Control word sampled at each rising edge.
    typedef struct packed {
        logic sclr_n;
        logic ld_n;
        logic cnt_en;
        logic chain_en;
    } spc_ctrl_t;

    // Strict priority: clear, then load, then count, else hold.
    function automatic spc_mode_e pick_mode(input spc_ctrl_t c);
        if (!c.sclr_n)
            return MODE_CLEAR;
        else if (!c.ld_n)
            return MODE_LOAD;
        else if (c.cnt_en && c.chain_en)
            return MODE_COUNT;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/spc_mode_decode.sv
`timescale 1ns/1ps
module spc_mode_decode
    import spc_pkg::*;
(
    input  spc_ctrl_t ctrl,
    output spc_mode_e mode
);
    always_comb begin
        mode = pick_mode(ctrl);
    end
endmodule

// File: rtl/spc_ones_chain.sv
`timescale 1ns/1ps
// Prefix AND chain: low_ones[i] is high when bits [i-1:0] of cur are all 1.
// low_ones[WIDTH] marks the terminal count.
module spc_ones_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH:0]   low_ones
);
    assign low_ones[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_link
        assign low_ones[i+1] = low_ones[i] & cur[i];
    end
endmodule

// File: rtl/spc_next_state.sv
`timescale 1ns/1ps
// Per-bit next-state selection. In count mode a bit toggles when all
// lower bits are 1.
module spc_next_state
    import spc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  spc_mode_e        mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH:0]   low_ones,
    output logic [WIDTH-1:0] nxt
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (mode)
                MODE_CLEAR: nxt[i] = 1'b0;
                MODE_LOAD:  nxt[i] = din[i];
                MODE_COUNT: nxt[i] = cur[i] ^ low_ones[i];
                default:    nxt[i] = cur[i];
            endcase
        end
    end
endmodule

// File: rtl/spc_carry.sv
`timescale 1ns/1ps
module spc_carry (
    input  logic chain_en,
    input  logic at_top,
    output logic tc
);
    assign tc = chain_en & at_top;
endmodule

// File: rtl/sync_preset_counter.sv
`timescale 1ns/1ps
module sync_preset_counter
    import spc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             sclr_n,
    input  logic             ld_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q,
    output logic             tc_out
);
    localparam int CHAIN_LEN = WIDTH + 1;

    spc_ctrl_t          ctrl;
    spc_mode_e          mode;
    logic [WIDTH-1:0]   cnt_r;
    logic [WIDTH-1:0]   cnt_nxt;
    logic [CHAIN_LEN-1:0] low_ones;

    assign ctrl = '{sclr_n: sclr_n, ld_n: ld_n, cnt_en: cnt_en, chain_en: chain_en};

    spc_mode_decode u_mode (
        .ctrl (ctrl),
        .mode (mode)
    );

    spc_ones_chain #(.WIDTH(WIDTH)) u_chain (
        .cur      (cnt_r),
        .low_ones (low_ones)
    );

    spc_next_state #(.WIDTH(WIDTH)) u_next (
        .mode     (mode),
        .cur      (cnt_r),
        .din      (d_in),
        .low_ones (low_ones),
        .nxt      (cnt_nxt)
    );

    spc_carry u_carry (
        .chain_en (chain_en),
        .at_top   (low_ones[WIDTH]),
        .tc       (tc_out)
    );

    // The clear is synchronous and is the only initialization.
    always_ff @(posedge clk) begin
        cnt_r <= cnt_nxt;
    end

    assign q = cnt_r;
endmodule

// File: rtl/spc_checker.sv
`timescale 1ns/1ps
module spc_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             sclr_n,
    input logic             ld_n,
    input logic             cnt_en,
    input logic             chain_en,
    input logic [WIDTH-1:0] d_in,
    input logic [WIDTH-1:0] q,
    input logic             tc_out
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // Properties are live only once a clear has given the register a value.
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        armed <= armed | ~sclr_n;
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        !sclr_n |=> (q == '0));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!armed)
        (sclr_n && !ld_n) |=> (q == $past(d_in)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!armed)
        (sclr_n && ld_n && cnt_en && chain_en) |=> (q == WIDTH'($past(q) + 1'b1)));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!armed)
        (sclr_n && ld_n && !(cnt_en && chain_en)) |=> $stable(q));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        (sclr_n && ld_n && cnt_en && chain_en && q == TOP) |=> (q == '0));

    // R6
    carry_match_chk: assert property (@(posedge clk) disable iff (!armed)
        tc_out == (chain_en && (q == TOP)));
endmodule

bind sync_preset_counter spc_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sync_preset_counter_tb.sv
`timescale 1ns/1ps
module sync_preset_counter_tb;
    logic       clk = 1'b0;
    logic       sclr_n, ld_n, cnt_en, chain_en;
    logic [3:0] d_in;
    logic [3:0] q;
    logic       tc_out;

    // cascade pair
    logic       c_sclr_n, c_cnt_en;
    logic [3:0] lo_q, hi_q;
    logic       lo_tc, hi_tc;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sync_preset_counter #(.WIDTH(4)) u_dut (
        .clk(clk), .sclr_n(sclr_n), .ld_n(ld_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .d_in(d_in), .q(q), .tc_out(tc_out));

    sync_preset_counter #(.WIDTH(4)) u_lo (
        .clk(clk), .sclr_n(c_sclr_n), .ld_n(1'b1), .cnt_en(c_cnt_en),
        .chain_en(1'b1), .d_in(4'h0), .q(lo_q), .tc_out(lo_tc));

    sync_preset_counter #(.WIDTH(4)) u_hi (
        .clk(clk), .sclr_n(c_sclr_n), .ld_n(1'b1), .cnt_en(c_cnt_en),
        .chain_en(lo_tc), .d_in(4'h0), .q(hi_q), .tc_out(hi_tc));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // advance to just after the next rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] exp;
        logic       p, t, cl, ld;
        string      tag;

        // Reset state: clear with every other control active (R1)
        sclr_n = 0; ld_n = 0; cnt_en = 1; chain_en = 1; d_in = 4'h7;
        c_sclr_n = 0; c_cnt_en = 0;
        step();
        chk("R1 clear beats load/count", {4'h0, q}, 8'h00);
        chk("R1 cascade cleared", {hi_q, lo_q}, 8'h00);

        // Sweep: every start value against every control combination
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                sclr_n = 1; ld_n = 0; cnt_en = 0; chain_en = 0; d_in = 4'(s);
                step();
                chk("R2 preload", {4'h0, q}, 8'(s));
                {cl, ld, p, t} = 4'(c);
                sclr_n = cl; ld_n = ld; cnt_en = p; chain_en = t;
                d_in = 4'(s) ^ 4'hA;
                #0.5;
                chk("R6 carry before edge", {7'h0, tc_out}, {7'h0, (t && s == 15)});
                if (!cl) begin
                    exp = 4'h0; tag = "R1 clear";
                end else if (!ld) begin
                    exp = 4'(s) ^ 4'hA; tag = "R2 load ignores enables";
                end else if (p && t) begin
                    exp = 4'((s + 1) % 16); tag = (s == 15) ? "R5 wrap" : "R3 count";
                end else begin
                    exp = 4'(s); tag = "R4 hold";
                end
                step();
                chk(tag, {4'h0, q}, {4'h0, exp});
                chk("R6 carry after edge", {7'h0, tc_out}, {7'h0, (t && exp == 4'hF)});
            end
        end

        // R7: input changes between edges do not move q
        sclr_n = 1; ld_n = 0; cnt_en = 0; chain_en = 0; d_in = 4'h5;
        step();
        ld_n = 0; d_in = 4'h9;
        #1;
        chk("R7 load not early", {4'h0, q}, 8'h05);
        step();
        chk("R7 load at edge", {4'h0, q}, 8'h09);
        ld_n = 1; sclr_n = 0;
        #1;
        chk("R7 clear not early", {4'h0, q}, 8'h09);
        sclr_n = 1;
        step();
        chk("R7 clear pulse between edges", {4'h0, q}, 8'h09);
        cnt_en = 1; chain_en = 1;
        #1;
        chk("R7 count not early", {4'h0, q}, 8'h09);
        step();
        chk("R3 count at edge", {4'h0, q}, 8'h0A);

        // R8: cascade 8-bit count through 0..255 and wrap
        c_sclr_n = 1; c_cnt_en = 1;
        for (int n = 1; n <= 256; n++) begin
            step();
            chk("R8 cascade count", {hi_q, lo_q}, 8'(n % 256));
            if (n == 255) chk("R8 upper carry at 255", {7'h0, hi_tc}, 8'h01);
            if (n == 254) chk("R8 upper carry low at 254", {7'h0, hi_tc}, 8'h00);
        end
        // pause via shared count enable
        c_cnt_en = 0;
        step();
        step();
        chk("R8 cascade pause", {hi_q, lo_q}, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule